// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the address for each beat of a four-beat burst. A start cycle captures a full external address. The low two bits become the starting offset of the burst. The upper bits become the fixed part of every address in that burst. Each later step cycle moves the low bits to the next position in the burst order. The high bits stay unchanged.

Two burst orders are supported. In interleaved order, the low bits are the starting offset XOR a beat count. In linear order, the low bits are the starting offset plus the beat count, wrapped to two bits. An order-select input chooses between them. It is taken once, at the first clock edge after reset is released, and is expected to stay static. A hold input freezes the block on any edge. After the fourth beat the sequence returns to the first address of the group.

Top module: `burst_seq_top`

## Requirements
- R1: While `rst_n` is low, and on the first edge after reset is released (when `start_i`, `step_i` and `hold_i` are all low), `addr_o` is all zeros.
- R2: An edge with `hold_i` low and `start_i` high makes `addr_o` equal to `addr_i` after that edge.
- R3: With interleaved order selected, steps starting from offsets 00, 01, 10 and 11 produce these low-bit sequences:
  - 00,01,10,11
  - 01,00,11,10
  - 10,11,00,01
  - 11,10,01,00
- R4: With linear order selected, steps starting from offsets 00, 01, 10 and 11 produce these low-bit sequences:
  - 00,01,10,11
  - 01,10,11,00
  - 10,11,00,01
  - 11,00,01,10
- R5: `ilv_i` high selects interleaved order and `ilv_i` low selects linear order. The value is taken at the first clock edge after `rst_n` rises.
- R6: An edge with `hold_i` high leaves `addr_o` unchanged, whatever the values of `start_i`, `step_i` and `addr_i`.
- R7: A step taken from the fourth beat of a burst returns `addr_o` to the first address of that burst.
- R8: A step leaves `addr_o[ADDR_W-1:2]` unchanged.
- R9: When `start_i` and `step_i` are both high (with `hold_i` low), the start wins: `addr_o` becomes `addr_i` and no step is taken.
- R10: An edge with `hold_i`, `start_i` and `step_i` all low leaves `addr_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| hold_i | input | 1 | High ignores the clock edge entirely |
| start_i | input | 1 | High begins a burst at `addr_i` |
| step_i | input | 1 | High advances to the next beat |
| ilv_i | input | 1 | Burst order select: 1 interleaved, 0 linear |
| addr_i | input | ADDR_W | Starting address of a burst |
| addr_o | output | ADDR_W | Current burst address |

## Verification
The bench builds the block with `BEAT_W` = 2 and `ADDR_W` = 10. This gives the four-beat group described above and an eight-bit upper field. The bench loads a different upper value on each burst, so any corruption of the upper field during steps shows up. Each order is brought up through its own reset, which exercises how the order select is captured. In each order, all four starting offsets are walked past the wrap point. Holds, start-with-step and idle edges are mixed in mid-burst.

// File: rtl/burst_pkg.sv
package burst_pkg;

  // Burst order, encoded as the level of the order-select input.
  typedef enum logic {
    ORD_LINEAR      = 1'b0,
    ORD_INTERLEAVED = 1'b1
  } burst_order_e;

endpackage

// File: rtl/burst_cfg.sv
module burst_cfg
  import burst_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ord_i,
  output burst_order_e ord_o
);

  logic         lock_q, lock_d;
  burst_order_e ord_q, ord_d;

  // The order select is captured on the first edge after reset, then held.
  always_comb begin
    lock_d = lock_q;
    ord_d  = ord_q;
    if (!lock_q) begin
      ord_d  = burst_order_e'(ord_i);
      lock_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      ord_q  <= ORD_INTERLEAVED;
    end else begin
      lock_q <= lock_d;
      ord_q  <= ord_d;
    end
  end

  assign ord_o = ord_q;

endmodule

// File: rtl/burst_ctr.sv
module burst_ctr #(
  parameter int ADDR_W = 20,
  parameter int BEAT_W = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     hold_i,
  input  logic                     start_i,
  input  logic                     step_i,
  input  logic [ADDR_W-1:0]        addr_i,
  output logic [ADDR_W-BEAT_W-1:0] upper_o,
  output logic [BEAT_W-1:0]        base_o,
  output logic [BEAT_W-1:0]        beat_o
);

  localparam int UP_W = ADDR_W - BEAT_W;
  localparam logic [BEAT_W-1:0] ONE = {{(BEAT_W-1){1'b0}}, 1'b1};

  logic [UP_W-1:0]   upper_q, upper_d;
  logic [BEAT_W-1:0] base_q, base_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic              en;

  assign en = !hold_i;

  always_comb begin
    upper_d = upper_q;
    base_d  = base_q;
    beat_d  = beat_q;
    if (start_i) begin
      upper_d = addr_i[ADDR_W-1:BEAT_W];
      base_d  = addr_i[BEAT_W-1:0];
      beat_d  = '0;
    end else if (step_i) begin
      beat_d  = beat_q + ONE;   // wraps naturally inside the group
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upper_q <= '0;
      base_q  <= '0;
      beat_q  <= '0;
    end else if (en) begin
      upper_q <= upper_d;
      base_q  <= base_d;
      beat_q  <= beat_d;
    end
  end

  assign upper_o = upper_q;
  assign base_o  = base_q;
  assign beat_o  = beat_q;

endmodule

// File: rtl/burst_map.sv
module burst_map
  import burst_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  burst_order_e      ord_i,
  input  logic [BEAT_W-1:0] base_i,
  input  logic [BEAT_W-1:0] beat_i,
  output logic [BEAT_W-1:0] low_o
);

  logic [BEAT_W-1:0] ilv_low;
  logic [BEAT_W-1:0] lin_low;

  // Interleaved: bitwise toggle of the offset by the beat count.
  for (genvar b = 0; b < BEAT_W; b++) begin : g_ilv
    assign ilv_low[b] = base_i[b] ^ beat_i[b];
  end

  // Linear: offset plus beat count, truncated to the group size.
  assign lin_low = base_i + beat_i;

  always_comb begin
    unique case (ord_i)
      ORD_INTERLEAVED: low_o = ilv_low;
      default:         low_o = lin_low;
    endcase
  end

endmodule

// File: rtl/burst_seq_top.sv
module burst_seq_top
  import burst_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold_i,
  input  logic              start_i,
  input  logic              step_i,
  input  logic              ilv_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o
);

  localparam int UP_W = ADDR_W - BEAT_W;

  burst_order_e      ord;
  logic [UP_W-1:0]   upper;
  logic [BEAT_W-1:0] base;
  logic [BEAT_W-1:0] beat;
  logic [BEAT_W-1:0] low;

  burst_cfg u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .ord_i (ilv_i),
    .ord_o (ord)
  );

  burst_ctr #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .hold_i  (hold_i),
    .start_i (start_i),
    .step_i  (step_i),
    .addr_i  (addr_i),
    .upper_o (upper),
    .base_o  (base),
    .beat_o  (beat)
  );

  burst_map #(.BEAT_W(BEAT_W)) u_map (
    .ord_i  (ord),
    .base_i (base),
    .beat_i (beat),
    .low_o  (low)
  );

  assign addr_o = {upper, low};

endmodule

// File: rtl/burst_seq_chk.sv
module burst_seq_chk #(
  parameter int ADDR_W = 20,
  parameter int BEAT_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hold_i,
  input logic              start_i,
  input logic              step_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [ADDR_W-1:0] addr_o
);

  // R1: output cleared while reset is held
  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_zero_r1: assert (addr_o == '0)
        else $error("reset value wrong");
    end
  end

  // R2
  p_start_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_i && start_i) |=> (addr_o == $past(addr_i)));

  // R3 / R4: each step moves to a different beat address
  p_step_moves_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_i && !start_i && step_i) |=>
      (addr_o[BEAT_W-1:0] != $past(addr_o[BEAT_W-1:0])));

  // R6
  p_hold_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> $stable(addr_o));

  // R8
  p_upper_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_i && !start_i) |=>
      (addr_o[ADDR_W-1:BEAT_W] == $past(addr_o[ADDR_W-1:BEAT_W])));

  // R10
  p_idle_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_i && !start_i && !step_i) |=> $stable(addr_o));

endmodule

bind burst_seq_top burst_seq_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .hold_i  (hold_i),
  .start_i (start_i),
  .step_i  (step_i),
  .addr_i  (addr_i),
  .addr_o  (addr_o)
);

// File: tb/sim_burst_seq_top.sv
`timescale 1ns/1ps
module sim_burst_seq_top;

  localparam int AW = 10;
  localparam int BW = 2;

  // Requirement tables: row = starting offset, beat k at bits [7-2k -: 2]
  localparam logic [7:0] ILV_T [4] = '{8'b00_01_10_11, 8'b01_00_11_10,
                                        8'b10_11_00_01, 8'b11_10_01_00};
  localparam logic [7:0] LIN_T [4] = '{8'b00_01_10_11, 8'b01_10_11_00,
                                        8'b10_11_00_01, 8'b11_00_01_10};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          hold_i = 1'b0, start_i = 1'b0, step_i = 1'b0, ilv_i = 1'b1;
  logic [AW-1:0] addr_i = '0;
  logic [AW-1:0] addr_o;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  burst_seq_top #(.ADDR_W(AW), .BEAT_W(BW)) u0 (
    .clk(clk), .rst_n(rst_n), .hold_i(hold_i), .start_i(start_i),
    .step_i(step_i), .ilv_i(ilv_i), .addr_i(addr_i), .addr_o(addr_o)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [AW-1:0] act, input logic [AW-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [1:0] tab(input bit ilv, input logic [1:0] st,
                                     input int k);
    logic [7:0] row;
    row = ilv ? ILV_T[st] : LIN_T[st];
    return row[7-2*k -: 2];
  endfunction

  // Behavioural reference model
  logic [AW-3:0] m_up = '0;
  logic [1:0]    m_st = '0;
  int            m_pos = 0;
  bit            m_ilv = 1'b1;
  bit            m_lock = 1'b0;
  string         m_tag = "R1";
  bit            m_stepped = 1'b0;
  logic [AW-1:0] prev_obs = '0;

  always @(posedge clk) begin
    m_stepped = 1'b0;
    if (!rst_n) begin
      m_up = '0; m_st = '0; m_pos = 0; m_lock = 1'b0; m_tag = "R1";
    end else begin
      if (!m_lock) begin m_ilv = ilv_i; m_lock = 1'b1; end
      if (hold_i) m_tag = "R6";
      else if (start_i) begin
        m_up = addr_i[AW-1:2]; m_st = addr_i[1:0]; m_pos = 0;
        m_tag = step_i ? "R9" : "R2";
      end else if (step_i) begin
        m_pos = (m_pos + 1) % 4;
        m_stepped = 1'b1;
        m_tag = (m_pos == 0) ? "R7" : (m_ilv ? "R3" : "R4");
      end else m_tag = "R10";
    end
  end

  always @(negedge clk) begin
    logic [AW-1:0] e;
    e = {m_up, tab(m_ilv, m_st, m_pos)};
    if (!done) begin
      chk(addr_o === e, m_tag, addr_o, e);
      if (m_stepped)
        chk(addr_o[AW-1:2] === prev_obs[AW-1:2], "R8", addr_o, prev_obs);
      prev_obs = addr_o;
    end
  end

  task automatic cyc(input bit h, input bit s, input bit t,
                     input logic [AW-1:0] a);
    @(negedge clk); #1;
    hold_i = h; start_i = s; step_i = t; addr_i = a;
  endtask

  task automatic peek(input logic [1:0] exp_low, input string tag);
    @(posedge clk); #2;
    chk(addr_o[1:0] === exp_low, tag, addr_o, {addr_o[AW-1:2], exp_low});
  endtask

  task automatic phase(input bit ilv);
    @(negedge clk); #1;
    rst_n = 1'b0; ilv_i = ilv; hold_i = 0; start_i = 0; step_i = 0;
    repeat (3) cyc(0, 0, 0, '0);
    @(negedge clk); #1; rst_n = 1'b1;
    cyc(0, 0, 0, '0);                 // R1: still zero after release
    cyc(0, 0, 1, '0);                 // step from reset state
    for (int off = 0; off < 4; off++) begin
      logic [AW-3:0] up;
      up = AW'(8'h3c + 8'(off * 37)) >> 2;
      cyc(0, 1, 0, {up, 2'(off)});
      cyc(0, 0, 1, '0);
      cyc(0, 0, 1, '0);
      cyc(1, 1, 1, {~up, 2'(~off)});  // R6: held edge ignores all
      cyc(0, 0, 0, '1);               // R10: idle edge
      cyc(0, 0, 1, '0);
      cyc(0, 0, 1, '0);               // R7: wrap to first beat
      cyc(0, 0, 1, '0);
    end
    cyc(0, 1, 1, {8'ha5, 2'b10});     // R9: start beats step
    cyc(0, 0, 1, '0);
    // R5: start at 01 and take one step; next low bits reveal the order
    cyc(0, 1, 0, {8'h5a, 2'b01});
    cyc(0, 0, 1, '0);
    peek(ilv ? 2'b00 : 2'b10, "R5");
    cyc(0, 0, 0, '0);
    cyc(0, 0, 0, '0);
  endtask

  initial begin
    phase(1'b1);
    phase(1'b0);
    phase(1'b1);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule